// File: doc/BRIEF.md
# Instruction Prefix Scanner and Access-Size Resolver

This block sits at the front of an instruction decoder. It takes the bytes of one instruction, one byte per cycle over a valid/ready handshake, and scans the operand-size and address-size prefixes, an optional REX byte, and an optional two-byte-map escape until it reaches the primary opcode. One cycle after the opcode byte is accepted, it pulses `done_o` and reports three sizes for that instruction: the effective operand size, the size of the memory access, and the effective address size. The sizes depend on the processor mode input, the prefixes, REX.W and the opcode.

Only a narrow set of opcodes is resolved: byte and full-width MOV store, zero- and sign-extending loads, the 32-to-64 sign-extending load, and register PUSH/POP. Every other opcode is reported as unsupported. When the prefixes run past the instruction-length limit, the block reports an error instead of a result. After either outcome it returns to scanning a fresh instruction.

Top module: `isr_access_resolver`

## Requirements
- R1: A byte is taken on a cycle where `byte_valid_i` and `byte_ready_o` are both high. `byte_ready_o` is high in every cycle except the cycle in which `done_o` is high.
- R2: Every accepted opcode byte, and every length error, produces exactly one `done_o` pulse one cycle wide. The pulse comes in the cycle after the byte is accepted. All prefix, REX and escape state is then cleared, so it cannot affect the next instruction.
- R3: Size codes on the outputs are 0 = 8 bit, 1 = 16 bit, 2 = 32 bit and 3 = 64 bit. `mode_i` is 0 for 16-bit mode and 1 for 32-bit mode, and a value with bit 1 set selects 64-bit mode. The default operand size is 16 bits in 16-bit mode and 32 bits otherwise. One or more 0x66 bytes select the other of 16 and 32.
- R4: In 64-bit mode, a REX byte with bit 3 (W) set makes the operand size 64 bits and overrides 0x66. A REX byte with W clear leaves the sizes unchanged.
- R5: Bytes 0x40–0x4F count as REX only in 64-bit mode and outside the two-byte map. A REX byte followed by 0x66 or 0x67 is discarded. In 16- and 32-bit mode, 0x40–0x4F is an opcode, reported as unsupported.
- R6: The address size is 16 or 32 bits by mode default in 16- and 32-bit mode, and 0x67 selects the other. In 64-bit mode it is 64 bits, or 32 bits with 0x67.
- R7: Opcode 0x88 reports an operand and memory size of 8 bits, whatever the prefixes. For opcode 0x89, the memory size equals the operand size.
- R8: For 0x0F 0xB6 and 0x0F 0xBE the memory size is 8 bits. For 0x0F 0xB7 and 0x0F 0xBF it is 16 bits. The operand size follows R3/R4.
- R9: Opcode 0x63 in 64-bit mode has an operand size per R3/R4. Its memory size is 16 bits when the operand size is 16 and 32 bits otherwise. In 16- and 32-bit mode, 0x63 is unsupported.
- R10: For 0x50–0x5F in 64-bit mode, the operand size is 64 bits, or 16 bits with 0x66 and no REX.W. In other modes it follows R3. The memory size equals the operand size.
- R11: For any other opcode, `unsup_o` is high, the operand and memory size codes are 0, and the address size follows R6.
- R12: If byte number MAX_LEN (15) of an instruction is accepted and is a prefix or an escape, the block reports `err_o` high, `unsup_o` low and all size codes 0. An opcode arriving as byte 15 resolves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Processor mode: 0 = 16-bit, 1 = 32-bit, bit 1 set = 64-bit |
| byte_valid_i | input | 1 | Instruction byte offered |
| byte_i | input | 8 | Instruction byte |
| byte_ready_o | output | 1 | Block can take a byte this cycle |
| done_o | output | 1 | One-cycle result pulse |
| unsup_o | output | 1 | Opcode is outside the resolved set |
| err_o | output | 1 | Instruction-length limit exceeded |
| opsize_o | output | 2 | Effective operand size code |
| memsize_o | output | 2 | Memory-access size code |
| addrsize_o | output | 2 | Effective address size code |

## Verification
The bench targets the corner cases where prefixes interact.

| Corner case | What a wrong design would do |
|---|---|
| 0x66 together with REX.W, in both orders | A design with the wrong priority reports 16 bits instead of 64. |
| A REX byte followed by 0x66 | A design that kept the stale REX reports 64 bits instead of 16. |
| 0x63 with each prefix mix | A design that ignored the opcode exceptions gets the 16/32-bit memory size wrong, or sizes it like MOV. |
| 0x40–0x4F outside 64-bit mode | A design that took them as REX consumes an opcode as a prefix. |
| Prefixes filling exactly 14 and exactly 15 bytes | An off-by-one limit either flags a legal instruction or misses the error. |
| A plain instruction right after an error | A design that left state behind corrupts that instruction's result. |

// File: rtl/isr_pkg.sv
package isr_pkg;

   typedef enum logic [1:0] {
      SZ8  = 2'd0,
      SZ16 = 2'd1,
      SZ32 = 2'd2,
      SZ64 = 2'd3
   } size_e;

   typedef enum logic [2:0] {
      CL_OPSZ  = 3'd0,
      CL_ADSZ  = 3'd1,
      CL_REX   = 3'd2,
      CL_ESC   = 3'd3,
      CL_OPC   = 3'd4
   } byte_class_e;

   typedef struct packed {
      logic esc;
      logic p66;
      logic p67;
      logic rex_v;
      logic rex_w;
   } scan_ctx_t;

   localparam logic [7:0] BYTE_OPSZ = 8'h66;
   localparam logic [7:0] BYTE_ADSZ = 8'h67;
   localparam logic [7:0] BYTE_ESC  = 8'h0F;

   function automatic logic is_long_mode(input logic [1:0] mode);
      return mode[1];
   endfunction

   function automatic logic is_short_mode(input logic [1:0] mode);
      return (mode == 2'd0);
   endfunction

endpackage

// File: rtl/isr_byte_class.sv
module isr_byte_class
   import isr_pkg::*;
(
   input  logic [7:0]  byte_i,
   input  logic        in_esc_i,
   input  logic        long_i,
   output byte_class_e class_o
);
   always_comb begin
      if (in_esc_i)                          class_o = CL_OPC;
      else if (byte_i == BYTE_OPSZ)          class_o = CL_OPSZ;
      else if (byte_i == BYTE_ADSZ)          class_o = CL_ADSZ;
      else if (byte_i == BYTE_ESC)           class_o = CL_ESC;
      else if (long_i && byte_i[7:4] == 4'h4) class_o = CL_REX;
      else                                   class_o = CL_OPC;
   end
endmodule

// File: rtl/isr_prefix_scan.sv
module isr_prefix_scan
   import isr_pkg::*;
#(
   parameter int MAX_LEN = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept_i,
   input  logic [7:0] byte_i,
   input  logic       long_i,
   output logic       fire_o,
   output logic       err_o,
   output scan_ctx_t  ctx_o
);
   localparam int CNT_W = $clog2(MAX_LEN + 1);
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(MAX_LEN - 1);

   scan_ctx_t        ctx_q, ctx_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   byte_class_e      cls;

   isr_byte_class u_class (
      .byte_i   (byte_i),
      .in_esc_i (ctx_q.esc),
      .long_i   (long_i),
      .class_o  (cls)
   );

   assign fire_o = accept_i && (cls == CL_OPC);
   assign err_o  = accept_i && (cls != CL_OPC) && (cnt_q == LAST_POS);
   assign ctx_o  = ctx_q;

   always_comb begin
      ctx_d = ctx_q;
      cnt_d = cnt_q;
      if (fire_o || err_o) begin
         ctx_d = '0;
         cnt_d = '0;
      end else if (accept_i) begin
         cnt_d = cnt_q + 1'b1;
         unique case (cls)
            CL_OPSZ: begin
               ctx_d.p66   = 1'b1;
               ctx_d.rex_v = 1'b0;
               ctx_d.rex_w = 1'b0;
            end
            CL_ADSZ: begin
               ctx_d.p67   = 1'b1;
               ctx_d.rex_v = 1'b0;
               ctx_d.rex_w = 1'b0;
            end
            CL_REX: begin
               ctx_d.rex_v = 1'b1;
               ctx_d.rex_w = byte_i[3];
            end
            CL_ESC:  ctx_d.esc = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctx_q <= '0;
         cnt_q <= '0;
      end else begin
         ctx_q <= ctx_d;
         cnt_q <= cnt_d;
      end
   end
endmodule

// File: rtl/isr_size_calc.sv
module isr_size_calc
   import isr_pkg::*;
(
   input  logic [1:0] mode_i,
   input  scan_ctx_t  ctx_i,
   input  logic [7:0] opcode_i,
   output size_e      op_o,
   output size_e      mem_o,
   output size_e      addr_o,
   output logic       unsup_o
);
   logic  long_m, short_m, wide;
   size_e gen_op, stack_op;

   assign long_m  = is_long_mode(mode_i);
   assign short_m = is_short_mode(mode_i);
   assign wide    = long_m && ctx_i.rex_v && ctx_i.rex_w;

   always_comb begin
      if (wide)                      gen_op = SZ64;
      else if (short_m ^ ctx_i.p66)  gen_op = SZ16;
      else                           gen_op = SZ32;

      if (!long_m)                   stack_op = gen_op;
      else if (ctx_i.p66 && !wide)   stack_op = SZ16;
      else                           stack_op = SZ64;

      if (long_m)                    addr_o = ctx_i.p67 ? SZ32 : SZ64;
      else if (short_m ^ ctx_i.p67)  addr_o = SZ16;
      else                           addr_o = SZ32;
   end

   always_comb begin
      op_o    = SZ8;
      mem_o   = SZ8;
      unsup_o = 1'b1;
      if (!ctx_i.esc) begin
         if (opcode_i == 8'h88) begin
            unsup_o = 1'b0;
         end else if (opcode_i == 8'h89) begin
            op_o    = gen_op;
            mem_o   = gen_op;
            unsup_o = 1'b0;
         end else if (opcode_i == 8'h63 && long_m) begin
            op_o    = gen_op;
            mem_o   = (gen_op == SZ16) ? SZ16 : SZ32;
            unsup_o = 1'b0;
         end else if (opcode_i[7:4] == 4'h5) begin
            op_o    = stack_op;
            mem_o   = stack_op;
            unsup_o = 1'b0;
         end
      end else begin
         if (opcode_i == 8'hB6 || opcode_i == 8'hBE) begin
            op_o    = gen_op;
            mem_o   = SZ8;
            unsup_o = 1'b0;
         end else if (opcode_i == 8'hB7 || opcode_i == 8'hBF) begin
            op_o    = gen_op;
            mem_o   = SZ16;
            unsup_o = 1'b0;
         end
      end
   end
endmodule

// File: rtl/isr_access_resolver.sv
module isr_access_resolver
   import isr_pkg::*;
#(
   parameter int MAX_LEN = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       byte_valid_i,
   input  logic [7:0] byte_i,
   output logic       byte_ready_o,
   output logic       done_o,
   output logic       unsup_o,
   output logic       err_o,
   output logic [1:0] opsize_o,
   output logic [1:0] memsize_o,
   output logic [1:0] addrsize_o
);
   initial begin
      if (MAX_LEN < 2 || MAX_LEN > 255)
         $fatal(1, "isr_access_resolver: MAX_LEN out of range");
   end

   logic      accept, fire, len_err;
   scan_ctx_t ctx;
   size_e     c_op, c_mem, c_addr;
   logic      c_unsup;

   logic      done_q, unsup_q, err_q;
   size_e     op_q, mem_q, addr_q;

   assign byte_ready_o = !done_q;
   assign accept       = byte_valid_i && byte_ready_o;

   isr_prefix_scan #(.MAX_LEN(MAX_LEN)) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .byte_i   (byte_i),
      .long_i   (is_long_mode(mode_i)),
      .fire_o   (fire),
      .err_o    (len_err),
      .ctx_o    (ctx)
   );

   isr_size_calc u_calc (
      .mode_i   (mode_i),
      .ctx_i    (ctx),
      .opcode_i (byte_i),
      .op_o     (c_op),
      .mem_o    (c_mem),
      .addr_o   (c_addr),
      .unsup_o  (c_unsup)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         unsup_q <= 1'b0;
         err_q   <= 1'b0;
         op_q    <= SZ8;
         mem_q   <= SZ8;
         addr_q  <= SZ8;
      end else if (fire) begin
         done_q  <= 1'b1;
         unsup_q <= c_unsup;
         err_q   <= 1'b0;
         op_q    <= c_op;
         mem_q   <= c_mem;
         addr_q  <= c_addr;
      end else if (len_err) begin
         done_q  <= 1'b1;
         unsup_q <= 1'b0;
         err_q   <= 1'b1;
         op_q    <= SZ8;
         mem_q   <= SZ8;
         addr_q  <= SZ8;
      end else begin
         done_q  <= 1'b0;
      end
   end

   assign done_o     = done_q;
   assign unsup_o    = unsup_q;
   assign err_o      = err_q;
   assign opsize_o   = op_q;
   assign memsize_o  = mem_q;
   assign addrsize_o = addr_q;
endmodule

// File: rtl/isr_access_resolver_sva.sv
module isr_access_resolver_sva (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_i,
   input logic       byte_valid_i,
   input logic       byte_ready_o,
   input logic       done_o,
   input logic       unsup_o,
   input logic       err_o,
   input logic [1:0] opsize_o,
   input logic [1:0] memsize_o,
   input logic [1:0] addrsize_o
);
   assert_ready_low_in_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !byte_ready_o);

   assert_done_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(byte_valid_i && byte_ready_o));

   assert_no_wide_outside_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !$past(mode_i[1])) |-> (opsize_o != 2'd3 && addrsize_o != 2'd3));

   assert_addr_never_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (addrsize_o != 2'd0));

   assert_unsup_sizes_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && unsup_o) |-> (opsize_o == 2'd0 && memsize_o == 2'd0));

   assert_err_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (!unsup_o && addrsize_o == 2'd0 && opsize_o == 2'd0));
endmodule

bind isr_access_resolver isr_access_resolver_sva u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_i       (mode_i),
   .byte_valid_i (byte_valid_i),
   .byte_ready_o (byte_ready_o),
   .done_o       (done_o),
   .unsup_o      (unsup_o),
   .err_o        (err_o),
   .opsize_o     (opsize_o),
   .memsize_o    (memsize_o),
   .addrsize_o   (addrsize_o)
);

// File: tb/isr_access_resolver_test.sv
`timescale 1ns/1ps
module isr_access_resolver_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_i = 2'd1;
   logic       byte_valid_i = 1'b0;
   logic [7:0] byte_i = 8'h00;
   logic       byte_ready_o, done_o, unsup_o, err_o;
   logic [1:0] opsize_o, memsize_o, addrsize_o;

   localparam logic [1:0] M16 = 2'd0, M32 = 2'd1, M64 = 2'd2;
   localparam logic [1:0] S8 = 2'd0, S16 = 2'd1, S32 = 2'd2, S64 = 2'd3;

   always #4 clk = ~clk;

   isr_access_resolver uut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .byte_valid_i(byte_valid_i), .byte_i(byte_i), .byte_ready_o(byte_ready_o),
      .done_o(done_o), .unsup_o(unsup_o), .err_o(err_o),
      .opsize_o(opsize_o), .memsize_o(memsize_o), .addrsize_o(addrsize_o)
   );

   typedef struct {
      bit         unsup;
      bit         err;
      logic [1:0] op;
      logic [1:0] mem;
      logic [1:0] addr;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   finished = 1'b0;
   bit   prev_done = 1'b0;

   task automatic send(input logic [1:0] m, input int n, input logic [127:0] bs,
                       input bit eu, input bit ee, input logic [1:0] eo,
                       input logic [1:0] em, input logic [1:0] ea, input string tag);
      exp_t e;
      e.unsup = eu; e.err = ee; e.op = eo; e.mem = em; e.addr = ea; e.tag = tag;
      q.push_back(e);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (k == 0) mode_i = m;
         byte_valid_i = 1'b1;
         byte_i = bs[8*(n-1-k) +: 8];
         while (!byte_ready_o) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      byte_valid_i = 1'b0;
   endtask

   // monitor: scoreboard compare plus handshake checks
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (done_o) begin
               exp_t e;
               checks++;
               if (byte_ready_o !== 1'b0 || prev_done) begin
                  fails++;
                  $display("FAIL R1/R2 handshake: ready=%0b prev_done=%0b expected ready=0 prev_done=0",
                           byte_ready_o, prev_done);
               end
               checks++;
               if (q.size() == 0) begin
                  fails++;
                  $display("FAIL R2 unexpected done: actual done=1 expected none");
               end else begin
                  e = q.pop_front();
                  if (unsup_o !== e.unsup || err_o !== e.err || opsize_o !== e.op ||
                      memsize_o !== e.mem || addrsize_o !== e.addr) begin
                     fails++;
                     $display("FAIL %s: actual u=%0b e=%0b op=%0d mem=%0d addr=%0d expected u=%0b e=%0b op=%0d mem=%0d addr=%0d",
                              e.tag, unsup_o, err_o, opsize_o, memsize_o, addrsize_o,
                              e.unsup, e.err, e.op, e.mem, e.addr);
                  end
               end
            end
            prev_done = done_o;
         end
      end
   end

   initial begin
      #(8 * 50000);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL R1 watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (byte_ready_o !== 1'b1 || done_o !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset: actual ready=%0b done=%0b expected ready=1 done=0",
                  byte_ready_o, done_o);
      end

      // R3 / R7 operand size defaults and 0x66
      send(M32, 1, {8'h89},               0, 0, S32, S32, S32, "R3 m32 mov");
      send(M32, 2, {8'h66, 8'h89},        0, 0, S16, S16, S32, "R3 m32 66 mov");
      send(M32, 1, {8'h89},               0, 0, S32, S32, S32, "R2 state cleared");
      send(M16, 1, {8'h89},               0, 0, S16, S16, S16, "R3 m16 mov");
      send(M16, 3, {8'h66, 8'h67, 8'h89}, 0, 0, S32, S32, S32, "R6 m16 66 67");
      send(M64, 1, {8'h89},               0, 0, S32, S32, S64, "R3 m64 mov");
      // R4 REX.W
      send(M64, 2, {8'h48, 8'h89},        0, 0, S64, S64, S64, "R4 rex.w");
      send(M64, 2, {8'h40, 8'h89},        0, 0, S32, S32, S64, "R4 rex no w");
      send(M64, 3, {8'h66, 8'h48, 8'h89}, 0, 0, S64, S64, S64, "R4 w beats 66");
      // R5 REX placement
      send(M64, 3, {8'h48, 8'h66, 8'h89}, 0, 0, S16, S16, S64, "R5 rex discarded");
      send(M32, 1, {8'h40},               1, 0, S8,  S8,  S32, "R5 4x opcode m32");
      // R6 address size
      send(M64, 2, {8'h67, 8'h89},        0, 0, S32, S32, S32, "R6 m64 67");
      send(M32, 2, {8'h67, 8'h89},        0, 0, S32, S32, S16, "R6 m32 67");
      // R7 byte store
      send(M64, 3, {8'h66, 8'h48, 8'h88}, 0, 0, S8,  S8,  S64, "R7 byte store");
      // R8 zero/sign extend
      send(M64, 2, {8'h0F, 8'hB6},        0, 0, S32, S8,  S64, "R8 movzx b");
      send(M64, 3, {8'h48, 8'h0F, 8'hB7}, 0, 0, S64, S16, S64, "R8 movzx w rex");
      send(M64, 3, {8'h66, 8'h0F, 8'hBE}, 0, 0, S16, S8,  S64, "R8 movsx b 66");
      send(M16, 2, {8'h0F, 8'hBF},        0, 0, S16, S16, S16, "R8 movsx w m16");
      // R9 MOVSXD
      send(M64, 1, {8'h63},               0, 0, S32, S32, S64, "R9 plain");
      send(M64, 2, {8'h66, 8'h63},        0, 0, S16, S16, S64, "R9 66");
      send(M64, 2, {8'h48, 8'h63},        0, 0, S64, S32, S64, "R9 rex.w");
      send(M64, 3, {8'h66, 8'h48, 8'h63}, 0, 0, S64, S32, S64, "R9 66 rex.w");
      send(M32, 1, {8'h63},               1, 0, S8,  S8,  S32, "R9 not long");
      // R10 PUSH/POP
      send(M64, 1, {8'h50},               0, 0, S64, S64, S64, "R10 push m64");
      send(M64, 2, {8'h66, 8'h57},        0, 0, S16, S16, S64, "R10 push 66");
      send(M64, 2, {8'h48, 8'h5F},        0, 0, S64, S64, S64, "R10 pop rex.w");
      send(M32, 1, {8'h58},               0, 0, S32, S32, S32, "R10 pop m32");
      send(M16, 1, {8'h50},               0, 0, S16, S16, S16, "R10 push m16");
      send(M32, 2, {8'h66, 8'h50},        0, 0, S16, S16, S32, "R10 push m32 66");
      // R11 unsupported
      send(M64, 2, {8'h0F, 8'h05},        1, 0, S8,  S8,  S64, "R11 two-byte other");
      send(M64, 1, {8'h2E},               1, 0, S8,  S8,  S64, "R11 segment byte");
      send(M64, 2, {8'h67, 8'h8B},        1, 0, S8,  S8,  S32, "R11 load opcode");
      send(M64, 2, {8'h0F, 8'h66},        1, 0, S8,  S8,  S64, "R11 66 after escape");
      // R12 length limit
      send(M32, 15, {{14{8'h66}}, 8'h89}, 0, 0, S16, S16, S32, "R12 opcode at 15");
      send(M32, 15, {15{8'h66}},          0, 1, S8,  S8,  S8,  "R12 prefix at 15");
      send(M32, 1, {8'h89},               0, 0, S32, S32, S32, "R12 R2 after error");
      send(M64, 15, {{14{8'h66}}, 8'h0F}, 0, 1, S8,  S8,  S8,  "R12 escape at 15");
      send(M64, 1, {8'h89},               0, 0, S32, S32, S64, "R2 after escape error");

      repeat (4) @(negedge clk);
      checks++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL R2 missing done: actual %0d pending expected 0", q.size());
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule